// File: doc/BRIEF.md
# Cubic B-spline Basis Weight Evaluator

This block turns a signed fixed-point sample offset into the weight that the centred cubic B-spline basis takes at that offset. An interpolator uses it to produce the four tap weights for one output point. It takes the offsets of the four neighbouring samples from the output position and multiplies each weight by its sample outside this block. One offset goes in per clock, and the weight comes out a fixed number of cycles later.

Internally the magnitude of the offset is compared against the knots at 1 and 2 to pick one of three segments: the inner arch, the outer tail, or the region where the basis is zero. The chosen segment's cubic is then evaluated in closed form with Horner's rule. Each multiply-add of the rule sits in its own pipeline stage. The constants are wired into the logic. The final value is rounded to nearest and saturated into a Q1.15 word.

Both sides are valid/ready streams. A beat moves when valid and ready are high on the same rising edge. When the consumer holds `out_ready` low while `out_valid` is high, the whole pipeline freezes, `out_weight` holds its value and `in_ready` drops in that same cycle. No beat is lost or duplicated. When `out_ready` stays high, `in_ready` stays high and one offset is accepted on every clock.

Top module: `spline_kernel_eval`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: For offset x with magnitude a = |x| in [0, 1), the weight equals (4 − 6a² + 3a³)/6 within 1 LSB of Q1.15.
- R3: For magnitude a in [1, 2), the weight equals (2 − a)³/6 within 1 LSB.
- R4: For magnitude a ≥ 2 (only code 16'h8000, i.e. −2.0, reaches it), the weight is exactly 0.
- R5: The weight depends only on |x|: offsets x and −x give identical weights.
- R6: `in_offset` is two's complement with 2 integer bits and 14 fraction bits (1.0 = 16384). `out_weight` is two's complement Q1.15 (1.0 = 32768), rounded to nearest and saturated to [−32768, 32767]. No weight is negative or above 2/3 + 1 LSB.
- R7: With `out_ready` held high, an offset accepted on one rising edge appears with `out_valid` high exactly 4 rising edges later, and `out_valid` is low on the cycles in between.
- R8: With `out_ready` high, `in_ready` is high, so one offset per clock is accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_weight` and `out_valid` hold and `in_ready` is low. Every accepted offset yields exactly one output, in order.
- R10: For t in [0, 1), the weights at offsets t+1, t, 1−t and 2−t sum to 32768 within 2 LSB. The bench checks t = 0, 0.25, 0.5 and 0.75.
- R11: The weight at offset 0 is 21845 (2/3) and at offset 1.0 is 5461 (1/6), each within 1 LSB. At offset 2.0 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offset beat present |
| in_ready | output | 1 | Block can take an offset this cycle |
| in_offset | input | 16 | Signed offset, 2 integer and 14 fraction bits |
| out_valid | output | 1 | Weight beat present |
| out_ready | input | 1 | Consumer takes the weight this cycle |
| out_weight | output | 16 | Signed Q1.15 basis weight |

## Verification
A wrong segment decision or a damaged Horner constant corrupts the weight of every offset in the affected range. The error reaches `out_weight` four edges after that offset is accepted. An exhaustive sweep of all 65536 offset codes therefore exposes it within the first pass over that range. A misaligned valid or a stage that fails to freeze under back-pressure shows up as a lost, repeated or shifted beat. This is visible when the output stream is compared in order with the accepted inputs, or as `out_weight` changing during a stall cycle. Rounding or saturation faults show up at the anchor points and in the four-tap sums, whose tolerances are only one and two LSB.

// File: rtl/spline_pkg.sv
`timescale 1ns/1ps
package spline_pkg;

  // Datapath formats: offsets Q2.14, internal accumulator Q7.24, weights Q1.15.
  localparam int IN_W     = 16;
  localparam int IN_FRAC  = 14;
  localparam int MAG_W    = IN_W + 1;
  localparam int ACC_W    = 32;
  localparam int ACC_FRAC = 24;
  localparam int OUT_W    = 16;
  localparam int OUT_FRAC = 15;
  localparam int STAGES   = 3;

  typedef enum logic [1:0] {
    SEG_INNER = 2'd0,
    SEG_TAIL  = 2'd1,
    SEG_NONE  = 2'd2
  } seg_e;

  localparam logic signed [ACC_W-1:0] K_ONE   = ACC_W'(1) <<< ACC_FRAC;
  localparam logic signed [ACC_W-1:0] K_HALF  = K_ONE >>> 1;
  localparam logic signed [ACC_W-1:0] K_TWO   = K_ONE <<< 1;
  localparam logic signed [ACC_W-1:0] K_2_3   = (2 * K_ONE + 1) / 3;
  localparam logic signed [ACC_W-1:0] K_4_3   = (4 * K_ONE + 1) / 3;
  localparam logic signed [ACC_W-1:0] K_1_6   = (K_ONE + 3) / 6;

  // Horner coefficient of power k for each segment, in the magnitude a.
  // inner: a^3/2 - a^2 + 2/3 ; tail: -a^3/6 + a^2 - 2a + 4/3 ; none: 0
  function automatic logic signed [ACC_W-1:0] seg_coef(seg_e s, int k);
    logic signed [ACC_W-1:0] c;
    c = '0;
    case (s)
      SEG_INNER: begin
        case (k)
          3: c = K_HALF;
          2: c = -K_ONE;
          1: c = '0;
          default: c = K_2_3;
        endcase
      end
      SEG_TAIL: begin
        case (k)
          3: c = -K_1_6;
          2: c = K_ONE;
          1: c = -K_TWO;
          default: c = K_4_3;
        endcase
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spline_seg_select.sv
`timescale 1ns/1ps
module spline_seg_select
  import spline_pkg::*;
#(
  parameter int W    = IN_W,
  parameter int FRAC = IN_FRAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_valid,
  input  logic [W-1:0]     in_offset,
  output logic             v_q,
  output logic [W:0]       mag_q,
  output seg_e             seg_q
);

  localparam logic [W:0] KNOT1 = (W+1)'(1) << FRAC;
  localparam logic [W:0] KNOT2 = (W+1)'(2) << FRAC;

  logic signed [W:0] ext;
  logic [W:0]        mag;
  seg_e              seg;

  always_comb begin
    ext = $signed({in_offset[W-1], in_offset});
    mag = in_offset[W-1] ? (W+1)'(-ext) : (W+1)'(ext);
    if (mag < KNOT1)      seg = SEG_INNER;
    else if (mag < KNOT2) seg = SEG_TAIL;
    else                  seg = SEG_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      mag_q <= '0;
      seg_q <= SEG_NONE;
    end else if (adv) begin
      v_q   <= in_valid;
      mag_q <= mag;
      seg_q <= seg;
    end
  end

  AST_MAG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> (mag_q <= KNOT2)); // R5

  AST_SEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && seg_q == SEG_INNER) |-> (mag_q < KNOT1)); // R2

endmodule

// File: rtl/spline_horner_stage.sv
`timescale 1ns/1ps
module spline_horner_stage
  import spline_pkg::*;
#(
  parameter int POW  = 2,
  parameter int AW   = MAG_W,
  parameter int AF   = IN_FRAC,
  parameter int CW   = ACC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 v_i,
  input  logic [AW-1:0]        mag_i,
  input  seg_e                 seg_i,
  input  logic signed [CW-1:0] acc_i,
  output logic                 v_o,
  output logic [AW-1:0]        mag_o,
  output seg_e                 seg_o,
  output logic signed [CW-1:0] acc_o
);

  localparam int PW = CW + AW + 1;

  logic signed [CW-1:0] nxt;

  // One Horner step: acc * a, rescaled to the accumulator format, plus the next constant.
  always_comb begin
    nxt = CW'((PW'(acc_i) * PW'($signed({1'b0, mag_i}))) >>> AF) + seg_coef(seg_i, POW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      mag_o <= '0;
      seg_o <= SEG_NONE;
      acc_o <= '0;
    end else if (adv) begin
      v_o   <= v_i;
      mag_o <= mag_i;
      seg_o <= seg_i;
      acc_o <= nxt;
    end
  end

  AST_NONE_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v_i && seg_i == SEG_NONE && acc_i == '0) |=> (acc_o == '0)); // R4

endmodule

// File: rtl/spline_round_sat.sv
`timescale 1ns/1ps
module spline_round_sat
  import spline_pkg::*;
#(
  parameter int CW = ACC_W,
  parameter int CF = ACC_FRAC,
  parameter int OW = OUT_W,
  parameter int OF = OUT_FRAC
) (
  input  logic signed [CW-1:0] acc_i,
  output logic [OW-1:0]        w_o
);

  localparam int SH = CF - OF;
  localparam logic signed [CW-1:0] HALF_LSB = CW'(1) <<< (SH - 1);
  localparam logic signed [CW-1:0] MAXV = CW'((2 ** (OW - 1)) - 1);
  localparam logic signed [CW-1:0] MINV = -CW'(2 ** (OW - 1));

  logic signed [CW-1:0] scaled;

  always_comb begin
    scaled = (acc_i + HALF_LSB) >>> SH;
    if (scaled > MAXV)      w_o = MAXV[OW-1:0];
    else if (scaled < MINV) w_o = MINV[OW-1:0];
    else                    w_o = scaled[OW-1:0];
  end

endmodule

// File: rtl/spline_kernel_eval.sv
`timescale 1ns/1ps
module spline_kernel_eval
  import spline_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_offset,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_weight
);

  localparam logic [MAG_W-1:0] MAG_TWO = MAG_W'(2) << IN_FRAC;
  localparam logic signed [OUT_W-1:0] W_MAX = OUT_W'(((2 ** OUT_FRAC) * 2) / 3 + 1);
  localparam logic signed [OUT_W-1:0] W_TAIL_MAX = OUT_W'((2 ** OUT_FRAC) / 6 + 1);

  logic adv;

  logic                    h_v   [0:STAGES];
  logic [MAG_W-1:0]        h_mag [0:STAGES];
  seg_e                    h_seg [0:STAGES];
  logic signed [ACC_W-1:0] h_acc [0:STAGES];

  // The whole pipeline freezes when the output beat is held.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  spline_seg_select u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .in_valid (in_valid),
    .in_offset(in_offset),
    .v_q      (h_v[0]),
    .mag_q    (h_mag[0]),
    .seg_q    (h_seg[0])
  );

  assign h_acc[0] = seg_coef(h_seg[0], 3);

  for (genvar g = 0; g < STAGES; g++) begin : g_horner
    spline_horner_stage #(.POW(STAGES - 1 - g)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .v_i   (h_v[g]),
      .mag_i (h_mag[g]),
      .seg_i (h_seg[g]),
      .acc_i (h_acc[g]),
      .v_o   (h_v[g+1]),
      .mag_o (h_mag[g+1]),
      .seg_o (h_seg[g+1]),
      .acc_o (h_acc[g+1])
    );
  end

  spline_round_sat u_rnd (
    .acc_i (h_acc[STAGES]),
    .w_o   (out_weight)
  );

  assign out_valid = h_v[STAGES];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_weight))); // R9

  AST_WEIGHT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_weight) >= 0 && $signed(out_weight) <= W_MAX)); // R6

  AST_ZERO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && h_v[STAGES-1] && h_seg[STAGES-1] == SEG_NONE) |=> (out_valid && out_weight == '0)); // R4

  AST_TAIL_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && h_v[STAGES-1] && h_seg[STAGES-1] == SEG_TAIL) |=> ($signed(out_weight) <= W_TAIL_MAX)); // R3

  AST_MAG_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (h_mag[STAGES] <= MAG_TWO)); // R5

endmodule

// File: tb/spline_kernel_eval_tb.sv
`timescale 1ns/1ps
module spline_kernel_eval_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic in_ready;
  logic [15:0] in_offset;
  logic out_valid;
  logic out_ready;
  logic [15:0] out_weight;

  always #10 clk = ~clk;

  spline_kernel_eval u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_offset (in_offset),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_weight(out_weight)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit reported = 0;
  int exp_q[$];
  int off_q[$];
  bit hold_pending = 0;
  int hold_w = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // Expected Q1.15 weight from the closed-form cubic B-spline.
  function automatic int ref_w(input int x);
    real a, w;
    a = (x < 0 ? -x : x) / 16384.0;
    if (a < 1.0)      w = (4.0 - 6.0 * a * a + 3.0 * a * a * a) / 6.0;
    else if (a < 2.0) w = (2.0 - a) * (2.0 - a) * (2.0 - a) / 6.0;
    else              w = 0.0;
    return int'(w * 32768.0);
  endfunction

  function automatic int sw(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int absdiff(input int p, input int q);
    return (p > q) ? p - q : q - p;
  endfunction

  // One streaming cycle: drive, then account for the handshakes of the next edge.
  task automatic step(input bit iv, input int off, input bit ordy);
    int e, o;
    @(negedge clk);
    in_valid  = iv;
    in_offset = 16'(off);
    out_ready = ordy;
    #1;
    if (hold_pending)
      chk(out_valid && sw(out_weight) == hold_w, "R9 held weight", sw(out_weight), hold_w);
    if (out_valid && !out_ready)
      chk(!in_ready, "R9 in_ready low during stall", int'(in_ready), 0);
    if (out_ready)
      chk(in_ready, "R8 in_ready with out_ready high", int'(in_ready), 1);
    hold_pending = out_valid && !out_ready;
    hold_w = sw(out_weight);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9 unexpected output beat", sw(out_weight), -1);
      end else begin
        e = exp_q.pop_front();
        o = off_q.pop_front();
        if ((o < 0 ? -o : o) < 16384)
          chk(absdiff(sw(out_weight), e) <= 1, "R2 R6 inner weight", sw(out_weight), e);
        else
          chk(absdiff(sw(out_weight), e) <= 1, "R3 R6 tail weight", sw(out_weight), e);
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_w(off));
      off_q.push_back(off);
    end
  endtask

  // Single beat on an empty pipeline; checks the four-edge latency.
  task automatic single(input int off, output int w);
    @(negedge clk);
    in_valid  = 1'b1;
    in_offset = 16'(off);
    out_ready = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      if (c < 4) chk(!out_valid, "R7 no early out_valid", int'(out_valid), 0);
      else       chk(out_valid,  "R7 out_valid after 4 edges", int'(out_valid), 1);
    end
    w = sw(out_weight);
  endtask

  initial begin
    #(20 * 190000);
    chk(0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int w0, w1, w2, wa, wb, sum;
    int t;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_offset = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);

    // Anchors
    single(0, w0);
    chk(absdiff(w0, 21845) <= 1, "R11 weight at 0", w0, 21845);
    single(16384, w1);
    chk(absdiff(w1, 5461) <= 1, "R11 weight at 1", w1, 5461);
    single(-32768, w2);
    chk(w2 == 0, "R4 R11 weight at 2", w2, 0);

    // Symmetry
    single(-16384, wa);
    chk(wa == w1, "R5 symmetry at 1", wa, w1);
    single(5000, wa);
    single(-5000, wb);
    chk(wa == wb, "R5 symmetry at 5000", wb, wa);
    single(20000, wa);
    single(-20000, wb);
    chk(wa == wb, "R5 symmetry at 20000", wb, wa);

    // Partition of unity
    for (int k = 0; k < 4; k++) begin
      t = k * 4096;
      single(t + 16384, wa); sum = wa;
      single(t, wa);         sum += wa;
      single(16384 - t, wa); sum += wa;
      single((t == 0) ? -32768 : 32768 - t, wa); sum += wa;
      chk(absdiff(sum, 32768) <= 2, "R10 four-tap sum", sum, 32768);
    end

    // Exhaustive sweep at full rate
    for (int i = 0; i < 65536; i++) step(1'b1, (i < 32768) ? i : i - 65536, 1'b1);
    // Sweep under back-pressure
    for (int i = 0; i < 3000; i++) step(1'b1, i * 21 - 32000, (i % 3) != 0);
    for (int i = 0; i < 12; i++) step(1'b0, 0, 1'b1);
    chk(exp_q.size() == 0, "R9 every beat delivered", exp_q.size(), 0);

    report();
    $finish;
  end

endmodule